// File: doc/BRIEF.md
# CAN Interrupt Code Encoder

This block gathers the interrupt events of a CAN controller into sticky flag bits, qualifies each flag with its own enable, and presents the result two ways. The first is a single registered interrupt request. The second is a 3-bit code that names the most urgent pending source, so a handler can branch on one value instead of scanning a status word. The sources are an error condition, three transmit buffers, two receive buffers, a bus-activity wake-up and a message-error flag. The message-error flag raises the request but has no code of its own.

Each event arrives as a one-cycle set pulse from the surrounding controller. A per-source condition level tells the block whether the cause of that flag is still present. Software clears a flag with a per-source clear pulse. That clear takes effect only once the condition has gone away, and a set in the same cycle wins over it. The flags are visible on an output so software can read them.

Top module: `ican_irq_encoder`

## Requirements
- R1: A source counts as qualified only when its flag bit and its enable bit are both 1. Bit order on set_i, busy_i, clr_i, en_i and flags_o: 0 error, 1 transmit buffer 0, 2 transmit buffer 1, 3 transmit buffer 2, 4 receive buffer 0, 5 receive buffer 1, 6 wake-up, 7 message error.
- R2: code_o is 000 when none of sources 0 to 6 is qualified.
- R3: The code values are: error 001, transmit buffer 2 010, transmit buffer 1 011, transmit buffer 0 100, receive buffer 1 101, receive buffer 0 110, wake-up 111.
- R4: A qualified error source yields code 001 regardless of every other source.
- R5: Below error the ranking is transmit buffer 0, then transmit buffer 1, then transmit buffer 2, then receive buffer 0, then receive buffer 1.
- R6: Wake-up yields 111 only when no other coded source is qualified.
- R7: A qualified message-error flag (bit 7) raises irq_o but never changes code_o.
- R8: irq_o is the OR of all eight qualified sources. It and code_o are registered, so they reflect the flags and enables present before the clock edge.
- R9: A set pulse makes the flag 1 after the next clock edge, and the flag stays 1 until a clear takes effect.
- R10: A clear pulse has no effect on a flag while that source's busy_i is 1.
- R11: When set_i and clr_i of a source are both 1 in one cycle, the flag is 1 afterwards.
- R12: While reset is asserted, flags_o, irq_o and code_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | 8 | Per-source event pulse |
| busy_i | input | 8 | Per-source condition still present |
| clr_i | input | 8 | Per-source software clear pulse |
| en_i | input | 8 | Per-source interrupt enable |
| flags_o | output | 8 | Sticky flag bits |
| irq_o | output | 1 | Registered interrupt request |
| code_o | output | 3 | Registered code of highest-priority source |

## Verification
The bench drives long random runs where several sources pend at once. These runs catch an encoder with two ranks swapped: a transmit buffer 1 reported above buffer 0, or wake-up reported while a receive buffer is still pending. Directed steps set a flag while the error source sits disabled, to show that the enable masks the code. They also issue a clear while the condition is held, which a careless flag would drop, and a set together with a clear, which a design that favours the clear would lose. A lone message-error flag is checked to raise the request with code 000, which catches a design that either leaves it out of the OR or gives it a code.

// File: rtl/ican_pkg.sv
package ican_pkg;
  localparam int NSRC  = 8;
  localparam int CODEW = 3;

  localparam int S_ERR  = 0;
  localparam int S_TX0  = 1;
  localparam int S_TX1  = 2;
  localparam int S_TX2  = 3;
  localparam int S_RX0  = 4;
  localparam int S_RX1  = 5;
  localparam int S_WAKE = 6;
  localparam int S_MERR = 7;

  localparam logic [CODEW-1:0] C_NONE = 3'd0;
  localparam logic [CODEW-1:0] C_ERR  = 3'd1;
  localparam logic [CODEW-1:0] C_TX2  = 3'd2;
  localparam logic [CODEW-1:0] C_TX1  = 3'd3;
  localparam logic [CODEW-1:0] C_TX0  = 3'd4;
  localparam logic [CODEW-1:0] C_RX1  = 3'd5;
  localparam logic [CODEW-1:0] C_RX0  = 3'd6;
  localparam logic [CODEW-1:0] C_WAKE = 3'd7;
endpackage

// File: rtl/ican_rst_sync.sv
module ican_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ican_flag_bank.sv
module ican_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] busy_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] load_en;
  logic [N-1:0] load_val;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // A set always loads 1; a clear loads 0 only once the cause is gone.
    always_comb begin
      load_en[i]  = set_i[i] | (clr_i[i] & ~busy_i[i]);
      load_val[i] = set_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[i] <= 1'b0;
      else if (load_en[i]) flag_q[i] <= load_val[i];
    end

    assert_set_sticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    assert_set_beats_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && clr_i[i]) |=> flag_q[i]);
    assert_clear_held_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && busy_i[i]) |=> flag_q[i]);
    assert_clear_takes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !busy_i[i] && !set_i[i]) |=> !flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ican_prio_enc.sv
module ican_prio_enc
  import ican_pkg::*;
(
  input  logic [NSRC-1:0]  qual_i,
  output logic [CODEW-1:0] code_o,
  output logic             any_o
);
  always_comb begin
    if      (qual_i[S_ERR])  code_o = C_ERR;
    else if (qual_i[S_TX0])  code_o = C_TX0;
    else if (qual_i[S_TX1])  code_o = C_TX1;
    else if (qual_i[S_TX2])  code_o = C_TX2;
    else if (qual_i[S_RX0])  code_o = C_RX0;
    else if (qual_i[S_RX1])  code_o = C_RX1;
    else if (qual_i[S_WAKE]) code_o = C_WAKE;
    else                     code_o = C_NONE;
  end

  // Message error joins the request but has no code.
  assign any_o = |qual_i;
endmodule

// File: rtl/ican_out_reg.sv
module ican_out_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  input  logic         req_i,
  output logic [W-1:0] code_o,
  output logic         req_o
);
  logic [W-1:0] code_q;
  logic         req_q;
  logic         upd_en;

  assign upd_en = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      req_q  <= 1'b0;
    end else if (upd_en) begin
      code_q <= code_i;
      req_q  <= req_i;
    end
  end

  assign code_o = code_q;
  assign req_o  = req_q;
endmodule

// File: rtl/ican_irq_encoder.sv
module ican_irq_encoder
  import ican_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  set_i,
  input  logic [NSRC-1:0]  busy_i,
  input  logic [NSRC-1:0]  clr_i,
  input  logic [NSRC-1:0]  en_i,
  output logic [NSRC-1:0]  flags_o,
  output logic             irq_o,
  output logic [CODEW-1:0] code_o
);
  logic             rst_n;
  logic [NSRC-1:0]  flags;
  logic [NSRC-1:0]  qual;
  logic [CODEW-1:0] code_d;
  logic             any_d;

  ican_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  ican_flag_bank #(.N(NSRC)) u_flags (
    .clk_i (clk_i), .rst_ni(rst_n), .set_i(set_i),
    .busy_i(busy_i), .clr_i(clr_i), .flag_o(flags)
  );

  // R1: qualification of each source by its enable
  assign qual = flags & en_i;

  ican_prio_enc u_enc (
    .qual_i(qual), .code_o(code_d), .any_o(any_d)
  );

  ican_out_reg #(.W(CODEW)) u_out (
    .clk_i (clk_i), .rst_ni(rst_n), .code_i(code_d),
    .req_i (any_d), .code_o(code_o), .req_o(irq_o)
  );

  assign flags_o = flags;

  assert_code_implies_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (code_o != C_NONE) |-> irq_o);
  assert_err_first_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    qual[S_ERR] |=> (code_o == C_ERR));
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (qual[S_WAKE:S_ERR] == '0) |=> (code_o == C_NONE));
  assert_wake_last_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (qual[S_WAKE] && qual[S_RX1:S_ERR] == '0) |=> (code_o == C_WAKE));
  assert_tx0_over_rest_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (qual[S_TX0] && !qual[S_ERR]) |=> (code_o == C_TX0));
  assert_merr_req_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    qual[S_MERR] |=> irq_o);
  assert_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (qual == '0) |=> !irq_o);
  assert_reset_quiet_R12: assert property (@(posedge clk_i)
    !rst_n |-> (flags == '0 && !irq_o && code_o == C_NONE));
endmodule

// File: tb/ican_irq_encoder_bench.sv
module ican_irq_encoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] set_i, busy_i, clr_i, en_i;
  logic [7:0] flags_o;
  logic       irq_o;
  logic [2:0] code_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m;  // model of the flags
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ican_irq_encoder u_ican_irq_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .busy_i(busy_i),
    .clr_i(clr_i), .en_i(en_i), .flags_o(flags_o), .irq_o(irq_o), .code_o(code_o)
  );

  // R3 code map, R4/R5/R6 ranking
  function automatic logic [2:0] exp_code(input logic [7:0] q);
    if      (q[0]) return 3'd1;
    else if (q[1]) return 3'd4;
    else if (q[2]) return 3'd3;
    else if (q[3]) return 3'd2;
    else if (q[4]) return 3'd6;
    else if (q[5]) return 3'd5;
    else if (q[6]) return 3'd7;
    else           return 3'd0;
  endfunction

  function automatic string code_tag(input logic [7:0] q);
    if (q[0])           return "R4";
    else if (|q[5:1])   return "R5";
    else if (q[6])      return "R6";
    else if (q[7])      return "R7";
    else                return "R2";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle and check the result after the edge.
  task automatic step(input logic [7:0] s, input logic [7:0] b,
                      input logic [7:0] c, input logic [7:0] e);
    logic [7:0] q, mn;
    string ftag;
    set_i = s; busy_i = b; clr_i = c; en_i = e;
    q  = m & e;  // R1
    mn = s | (m & ~(c & ~b));
    if (|(c & b & m & ~s)) ftag = "R10";
    else if (|(s & c))     ftag = "R11";
    else                   ftag = "R9";
    @(negedge clk_i);
    check({"flags ", ftag}, flags_o, mn);
    check({"code R3 ", code_tag(q)}, code_o, exp_code(q));
    check(q[7] && q[6:0] == 0 ? "irq R7" : "irq R1 R8", irq_o, |q);
    m = mn;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m = '0;
    rst_ni = 1'b0; set_i = '0; busy_i = '0; clr_i = '0; en_i = '1;
    repeat (3) @(negedge clk_i);
    set_i = 8'hFF;  // ignored in reset
    @(negedge clk_i);
    check("reset flags R12", flags_o, 0);
    check("reset irq R12", irq_o, 0);
    check("reset code R12", code_o, 0);
    set_i = '0;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R9: set tx1 with error disabled; code reports tx1
    step(8'h04, 8'h00, 8'h00, 8'hFE);
    step(8'h00, 8'h00, 8'h00, 8'hFE);
    // R10: clear while condition present is ignored
    step(8'h00, 8'h04, 8'h04, 8'hFE);
    step(8'h00, 8'h00, 8'h00, 8'hFE);
    // clear once gone
    step(8'h00, 8'h00, 8'h04, 8'hFE);
    step(8'h00, 8'h00, 8'h00, 8'hFE);
    // R11: set and clear together
    step(8'h10, 8'h00, 8'h10, 8'hFF);
    step(8'h00, 8'h00, 8'h00, 8'hFF);
    step(8'h00, 8'h00, 8'h10, 8'hFF);
    // R7: message error alone -> irq, code 0
    step(8'h80, 8'h00, 8'h00, 8'hFF);
    step(8'h00, 8'h00, 8'h00, 8'hFF);
    // R6: wake with rx1 pending, then rx1 cleared
    step(8'h60, 8'h00, 8'h80, 8'hFF);
    step(8'h00, 8'h00, 8'h20, 8'hFF);
    step(8'h00, 8'h00, 8'h00, 8'hFF);
    // R4: error over everything
    step(8'h7F, 8'h00, 8'h00, 8'hFF);
    step(8'h00, 8'h00, 8'h00, 8'hFF);
    step(8'h00, 8'h00, 8'hFF, 8'hFF);
    step(8'h00, 8'h00, 8'h00, 8'hFF);

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] s, b, c, e;
      s = 8'($urandom) & 8'($urandom) & 8'($urandom);
      b = 8'($urandom) & 8'($urandom);
      c = 8'($urandom);
      e = 8'($urandom) | 8'($urandom);
      step(s, b, c, e);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule